// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Target

This block models a small two-wire serial EEPROM that answers on a shared clock/data bus. It holds 128 bytes in on-chip registers. It watches the bus clock and data lines through synchronisers and finds start and stop conditions. After a start it takes in one address byte. The upper seven bits of that byte are a memory word address, sent most significant bit first, and the last bit selects write (0) or read (1). Every byte that the target receives is acknowledged by pulling the data line low during the ninth clock. Reads are driven out on the falling clock edges and end when the controller stops acknowledging.

A write transaction delivers one to four data bytes. Each byte lands in a small page buffer at the lane picked by the low two address bits. Those bits advance after every byte and wrap inside the 4-byte page. A stop that follows at least one complete data byte commits the whole buffer to memory. It then starts a timed internal write cycle of `WRITE_CYCLES` system clocks. For that whole cycle `busy_o` is high and the target ignores the bus.

The controller is a finite-state machine with these states:
- ST_IDLE: standby.
- ST_ADDR_BITS, then ST_ADDR_WAIT, then ST_ADDR_ACK: address byte in, then acknowledge.
- ST_WR_BITS, then ST_WR_WAIT, then ST_WR_ACK: one data byte in, then acknowledge; the loop returns to ST_WR_BITS.
- ST_RD_BITS, then ST_RD_ACKCHK, then ST_RD_NEXT: one byte out, the controller's acknowledge sampled, the next byte loaded.
- ST_BUSY: internal write cycle.

Transitions:
- A start from any state except ST_BUSY goes to ST_ADDR_BITS.
- A stop goes to ST_BUSY when bytes are buffered, and to ST_IDLE otherwise.
- ST_ADDR_ACK branches on the read/write bit.
- A high (not acknowledged) bit in ST_RD_ACKCHK returns to ST_IDLE.
- ST_BUSY returns to ST_IDLE when the timer expires.

Top module: `tw_eeprom_target`

## Requirements
- R1: After reset the target releases the data line (`sda_pull_o` = 0) and `busy_o` is 0.
- R2: A transaction begins only after a start condition, which is a falling data line while the clock is high. Bits clocked without a start get no acknowledge.
- R3: The address byte is sent MSB first. Bits [7:1] are the word address and bit 0 is read/write (0 write, 1 read). When the target is not busy, it acknowledges the address byte by holding the data line low through the ninth clock.
- R4: Each complete data byte of a write is acknowledged. After the stop, the memory holds the byte at its addressed location.
- R5: Within a write, only the low 2 address bits advance after each byte, wrapping within the 4-byte page. A later byte to the same lane replaces an earlier one.
- R6: A stop (rising data line while the clock is high) that follows at least one complete data byte raises `busy_o` for exactly `WRITE_CYCLES` clocks. A stop with no data byte leaves `busy_o` low.
- R7: While busy, the target gives no acknowledge and leaves memory unchanged for any bus traffic.
- R8: A read ignores the address field. It starts at the current pointer, which is the write address plus the bytes accepted (wrapped in the page), or one past the last byte read. It sends bytes MSB first and advances the full 7-bit pointer, wrapping from 127 to 0.
- R9: A high (not acknowledged) bit after a read byte ends the read, and the data line is released.
- R10: A repeated start before the stop discards the data bytes buffered so far.
- R11: The target changes the data line only while the clock is low, except when a start or stop aborts a transfer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired-AND level) |
| sda_pull_o | output | 1 | When high, the open-drain driver pulls the data line low |
| busy_o | output | 1 | High for the whole internal write cycle |

## Verification
Several properties are checked on every cycle: the data line is quiet while busy, a commit always leads into the busy state, the data line changes only with the clock low, a read releases the line after a high acknowledge bit, the page bits of the pointer do not move during a write, and the write timer stays in range. Only the bench scenarios can show the stored values and the wrap order within a page. The same holds for the exact busy length, the current-address pointer across writes and reads, and the effects of discarding a write on a repeated start or of traffic during the busy cycle.

// File: rtl/tw_eeprom_pkg.sv
package tw_eeprom_pkg;

    localparam int WORD_W = 8;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR_BITS,
        ST_ADDR_WAIT,
        ST_ADDR_ACK,
        ST_WR_BITS,
        ST_WR_WAIT,
        ST_WR_ACK,
        ST_RD_BITS,
        ST_RD_ACKCHK,
        ST_RD_NEXT,
        ST_BUSY
    } tw_state_e;

endpackage

// File: rtl/tw_line_sampler.sv
module tw_line_sampler #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);

    logic scl_q;
    logic sda_q;

    generate
        if (SYNC_STAGES > 1) begin : g_chain
            logic [SYNC_STAGES-1:0] scl_sync;
            logic [SYNC_STAGES-1:0] sda_sync;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_sync <= '1;
                    sda_sync <= '1;
                end else begin
                    scl_sync <= {scl_sync[SYNC_STAGES-2:0], scl_in};
                    sda_sync <= {sda_sync[SYNC_STAGES-2:0], sda_in};
                end
            end
            assign scl_s = scl_sync[SYNC_STAGES-1];
            assign sda_s = sda_sync[SYNC_STAGES-1];
        end else begin : g_single
            logic scl_r;
            logic sda_r;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    scl_r <= 1'b1;
                    sda_r <= 1'b1;
                end else begin
                    scl_r <= scl_in;
                    sda_r <= sda_in;
                end
            end
            assign scl_s = scl_r;
            assign sda_s = sda_r;
        end
    endgenerate

    // history registers for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_s;
            sda_q <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign bus_start = scl_s & scl_q & sda_q & ~sda_s;
    assign bus_stop  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/tw_write_timer.sv
module tw_write_timer #(
    parameter int CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);

    localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= LAST;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    assign expired = (cnt == '0);

    // R6: the countdown never leaves the programmed window
    assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LAST);

endmodule

// File: rtl/tw_byte_store.sv
module tw_byte_store
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int PAGE_W = 2
) (
    input  logic                                 clk,
    input  logic                                 commit,
    input  logic [ADDR_W-PAGE_W-1:0]             page,
    input  logic [(1<<PAGE_W)-1:0][WORD_W-1:0]   lane_data,
    input  logic [(1<<PAGE_W)-1:0]               lane_valid,
    input  logic [ADDR_W-1:0]                    rd_addr,
    output logic [WORD_W-1:0]                    rd_data
);

    localparam int DEPTH = 1 << ADDR_W;
    localparam int LANES = 1 << PAGE_W;

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (commit && lane_valid[i]) begin
                mem[{page, PAGE_W'(i)}] <= lane_data[i];
            end
        end
    end

    assign rd_data = mem[rd_addr];

endmodule

// File: rtl/tw_eeprom_target.sv
module tw_eeprom_target
    import tw_eeprom_pkg::*;
#(
    parameter int PAGE_W       = 2,
    parameter int WRITE_CYCLES = 2000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_pull_o,
    output logic busy_o
);

    localparam int ADDR_W = WORD_W - 1;
    localparam int LANES  = 1 << PAGE_W;
    localparam int CNT_W  = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(WORD_W - 1);

    tw_state_e state, state_nx;

    logic scl_s, sda_s, scl_rise, scl_fall, bus_start, bus_stop;
    logic tmr_expired, store_commit;

    logic [CNT_W-1:0]               bitcnt;
    logic [WORD_W-1:0]              shreg;
    logic [WORD_W-1:0]              byte_nx;
    logic [WORD_W-1:0]              rd_shift;
    logic [WORD_W-1:0]              rd_data;
    logic                           rw_q;
    logic [ADDR_W-1:0]              ptr;
    logic [LANES-1:0][WORD_W-1:0]   buf_data;
    logic [LANES-1:0]               buf_valid;

    tw_line_sampler #(.SYNC_STAGES(SYNC_STAGES)) u_sampler (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_i),
        .sda_in    (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .bus_start (bus_start),
        .bus_stop  (bus_stop)
    );

    assign store_commit = (state != ST_BUSY) && !bus_start && bus_stop && (|buf_valid);

    tw_write_timer #(.CYCLES(WRITE_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (store_commit),
        .expired (tmr_expired)
    );

    tw_byte_store #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_store (
        .clk        (clk),
        .commit     (store_commit),
        .page       (ptr[ADDR_W-1:PAGE_W]),
        .lane_data  (buf_data),
        .lane_valid (buf_valid),
        .rd_addr    (ptr),
        .rd_data    (rd_data)
    );

    assign byte_nx = {shreg[WORD_W-2:0], sda_s};

    // next-state logic
    always_comb begin
        state_nx = state;
        if (state == ST_BUSY) begin
            if (tmr_expired) state_nx = ST_IDLE;
        end else if (bus_start) begin
            state_nx = ST_ADDR_BITS;
        end else if (bus_stop) begin
            state_nx = (|buf_valid) ? ST_BUSY : ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:      state_nx = ST_IDLE;
                ST_ADDR_BITS: if (scl_rise && bitcnt == LAST_BIT) state_nx = ST_ADDR_WAIT;
                ST_ADDR_WAIT: if (scl_fall) state_nx = ST_ADDR_ACK;
                ST_ADDR_ACK:  if (scl_fall) state_nx = rw_q ? ST_RD_BITS : ST_WR_BITS;
                ST_WR_BITS:   if (scl_rise && bitcnt == LAST_BIT) state_nx = ST_WR_WAIT;
                ST_WR_WAIT:   if (scl_fall) state_nx = ST_WR_ACK;
                ST_WR_ACK:    if (scl_fall) state_nx = ST_WR_BITS;
                ST_RD_BITS:   if (scl_fall && bitcnt == LAST_BIT) state_nx = ST_RD_ACKCHK;
                ST_RD_ACKCHK: if (scl_rise) state_nx = sda_s ? ST_IDLE : ST_RD_NEXT;
                ST_RD_NEXT:   if (scl_fall) state_nx = ST_RD_BITS;
                ST_BUSY:      state_nx = ST_BUSY;
                default:      state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            shreg     <= '0;
            rd_shift  <= '0;
            rw_q      <= 1'b0;
            ptr       <= '0;
            buf_data  <= '0;
            buf_valid <= '0;
        end else if (state != ST_BUSY && bus_start) begin
            bitcnt    <= '0;
            buf_valid <= '0;
        end else if (state != ST_BUSY && bus_stop) begin
            buf_valid <= '0;
        end else begin
            case (state)
                ST_ADDR_BITS: if (scl_rise) begin
                    shreg  <= byte_nx;
                    bitcnt <= bitcnt + CNT_W'(1);
                    if (bitcnt == LAST_BIT) begin
                        rw_q <= sda_s;
                        if (!sda_s) ptr <= shreg[ADDR_W-1:0];
                    end
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    if (rw_q) begin
                        rd_shift <= rd_data;
                        ptr      <= ptr + ADDR_W'(1);
                    end
                end
                ST_WR_BITS: if (scl_rise) begin
                    shreg  <= byte_nx;
                    bitcnt <= bitcnt + CNT_W'(1);
                end
                ST_WR_WAIT: if (scl_fall) begin
                    buf_data[ptr[PAGE_W-1:0]]  <= shreg;
                    buf_valid[ptr[PAGE_W-1:0]] <= 1'b1;
                    ptr <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                end
                ST_RD_BITS: if (scl_fall) begin
                    rd_shift <= {rd_shift[WORD_W-2:0], 1'b0};
                    bitcnt   <= bitcnt + CNT_W'(1);
                end
                ST_RD_NEXT: if (scl_fall) begin
                    rd_shift <= rd_data;
                    ptr      <= ptr + ADDR_W'(1);
                    bitcnt   <= '0;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_pull_o = 1'b0;
        busy_o     = 1'b0;
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_pull_o = 1'b1;
            ST_RD_BITS:             sda_pull_o = ~rd_shift[WORD_W-1];
            ST_BUSY:                busy_o     = 1'b1;
            default: ;
        endcase
    end

    // R7: no drive and no pending bytes during the write cycle
    assert_busy_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (!sda_pull_o && buf_valid == '0));

    // R6: a commit always leads into the timed write cycle
    assert_commit_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $past(store_commit) |-> busy_o);

    // R11: data line moves only with the clock low, unless a condition aborted
    assert_sda_low_clk_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_pull_o != $past(sda_pull_o)) |-> (!scl_s || $past(bus_start) || $past(bus_stop)));

    // R9: a high acknowledge bit ends the read with the line released
    assert_read_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_RD_ACKCHK && scl_rise && sda_s && !bus_stop) |-> !sda_pull_o);

    // R5: storing a byte never moves the page part of the pointer
    assert_page_fixed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state == ST_WR_WAIT && scl_fall && !bus_start && !bus_stop)
        |-> ptr[ADDR_W-1:PAGE_W] == $past(ptr[ADDR_W-1:PAGE_W]));

endmodule

// File: tb/tw_eeprom_target_bench.sv
module tw_eeprom_target_bench;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int WC = 300;
    localparam int Q  = 5;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic tb_sda = 1'b1;
    logic pull, busy;
    logic sda_line;

    assign sda_line = tb_sda & ~pull;

    always #2.5 clk = ~clk;

    tw_eeprom_target #(.PAGE_W(2), .WRITE_CYCLES(WC), .SYNC_STAGES(2)) u_tw_eeprom_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_pull_o (pull),
        .busy_o     (busy)
    );

    int checks = 0;
    int fails  = 0;
    int run = 0;
    int last_run = 0;
    logic [7:0] model [128];

    always @(posedge clk) begin
        if (busy) run = run + 1;
        else begin
            if (run != 0) last_run = run;
            run = 0;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic qw(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic bus_start_c();
        tb_sda = 1'b1; qw(1);
        scl = 1'b1;    qw(1);
        tb_sda = 1'b0; qw(1);
        scl = 1'b0;    qw(1);
    endtask

    task automatic bus_stop_c();
        tb_sda = 1'b0; qw(1);
        scl = 1'b1;    qw(1);
        tb_sda = 1'b1; qw(1);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            tb_sda = b[i]; qw(1);
            scl = 1'b1;    qw(2);
            scl = 1'b0;    qw(1);
        end
        tb_sda = 1'b1; qw(1);
        scl = 1'b1;    qw(1);
        acked = (sda_line == 1'b0);
        qw(1);
        scl = 1'b0;    qw(1);
    endtask

    task automatic recv_byte(input bit ack, output logic [7:0] d);
        logic early;
        tb_sda = 1'b1;
        d = '0;
        for (int i = 0; i < 8; i++) begin
            qw(1);
            scl = 1'b1; qw(1);
            early = sda_line;
            d = {d[6:0], sda_line};
            repeat (Q - 1) @(negedge clk);
            chk(early == sda_line, "R11 data stable while clock high", int'(sda_line), int'(early));
            @(negedge clk);
            scl = 1'b0;
        end
        tb_sda = ack ? 1'b0 : 1'b1; qw(1);
        scl = 1'b1; qw(2);
        scl = 1'b0; qw(1);
        tb_sda = 1'b1;
    endtask

    function automatic logic [7:0] pat(input int a);
        return 8'((a * 29 + 83) ^ (a >> 3));
    endfunction

    task automatic wait_idle();
        while (busy) @(negedge clk);
        qw(2);
    endtask

    task automatic set_ptr(input logic [6:0] a);
        bit ak;
        bus_start_c();
        send_byte({a, 1'b0}, ak);
        chk(ak, "R3 pointer address ack", int'(ak), 1);
        bus_stop_c();
        qw(1);
        chk(busy == 1'b0, "R6 no busy without data", int'(busy), 0);
    endtask

    task automatic read_check(input int n, input logic [6:0] first, input string req);
        bit ak;
        logic [7:0] d;
        bus_start_c();
        send_byte({7'h55, 1'b1}, ak);
        chk(ak, "R3 read address ack", int'(ak), 1);
        for (int i = 0; i < n; i++) begin
            recv_byte(i != n - 1, d);
            chk(d == model[7'(first + 7'(i))], req, int'(d), int'(model[7'(first + 7'(i))]));
        end
        qw(1);
        chk(sda_line == 1'b1, "R9 line released after high ack bit", int'(sda_line), 1);
        bus_stop_c();
    endtask

    task automatic report();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
        report();
        $finish;
    end

    initial begin
        bit ak;
        logic [6:0] a;
        logic [7:0] d;

        // R1 reset state
        repeat (10) @(negedge clk);
        chk(pull == 1'b0, "R1 line released in reset", int'(pull), 0);
        chk(busy == 1'b0, "R1 busy low in reset", int'(busy), 0);
        rst_n = 1'b1;
        repeat (10) @(negedge clk);
        chk(pull == 1'b0 && busy == 1'b0, "R1 idle after reset", int'({pull, busy}), 0);

        // R2 bits without a start get no acknowledge
        scl = 1'b0; qw(1);
        send_byte(8'h00, ak);
        chk(!ak, "R2 no ack without start", int'(ak), 0);
        bus_stop_c();
        qw(1);
        chk(busy == 1'b0, "R2 no write cycle without start", int'(busy), 0);

        // R4/R5/R6 page-write sweep of the whole memory
        for (int p = 0; p < 32; p++) begin
            bus_start_c();
            send_byte({7'(p * 4), 1'b0}, ak);
            chk(ak, "R3 write address ack", int'(ak), 1);
            for (int k = 0; k < 4; k++) begin
                send_byte(pat(p * 4 + k), ak);
                chk(ak, "R4 data byte ack", int'(ak), 1);
                model[p * 4 + k] = pat(p * 4 + k);
            end
            bus_stop_c();
            chk(busy == 1'b1, "R6 busy after stop", int'(busy), 1);
            wait_idle();
            chk(last_run == WC, "R6 busy length", last_run, WC);
        end

        // R8 full read from pointer 0, wrap 127 -> 0, address field ignored
        set_ptr(7'd0);
        read_check(129, 7'd0, "R8 sequential read");

        // R5 page wrap with six bytes from 0x41
        bus_start_c();
        send_byte({7'h41, 1'b0}, ak);
        chk(ak, "R3 write address ack", int'(ak), 1);
        for (int k = 0; k < 6; k++) begin
            d = 8'(8'hC0 + k);
            send_byte(d, ak);
            chk(ak, "R5 page byte ack", int'(ak), 1);
            a = {5'h10, 2'(2'd1 + 2'(k))};
            model[a] = d;
        end
        bus_stop_c();
        wait_idle();
        chk(last_run == WC, "R6 busy length after page write", last_run, WC);
        // pointer now 0x41 + 6 wrapped in page = 0x43
        read_check(1, 7'h43, "R8 current address after write");
        read_check(1, 7'h44, "R8 pointer advances past page on read");
        set_ptr(7'h40);
        read_check(4, 7'h40, "R5 page lanes after wrap");

        // R7 traffic during the write cycle is ignored
        bus_start_c();
        send_byte({7'h10, 1'b0}, ak);
        send_byte(8'h3C, ak);
        chk(ak, "R4 single byte ack", int'(ak), 1);
        model[7'h10] = 8'h3C;
        bus_stop_c();
        bus_start_c();
        send_byte({7'h20, 1'b0}, ak);
        chk(!ak, "R7 no ack while busy", int'(ak), 0);
        chk(busy == 1'b1, "R7 still busy during ignored traffic", int'(busy), 1);
        bus_stop_c();
        wait_idle();
        set_ptr(7'h10);
        read_check(1, 7'h10, "R4 single byte stored");
        set_ptr(7'h20);
        read_check(1, 7'h20, "R7 memory unchanged by busy traffic");

        // R10 repeated start discards buffered bytes
        bus_start_c();
        send_byte({7'h30, 1'b0}, ak);
        send_byte(8'h5A, ak);
        chk(ak, "R10 data ack before restart", int'(ak), 1);
        bus_start_c();
        send_byte({7'h31, 1'b0}, ak);
        chk(ak, "R10 address ack after restart", int'(ak), 1);
        bus_stop_c();
        qw(1);
        chk(busy == 1'b0, "R10 no write cycle after discard", int'(busy), 0);
        set_ptr(7'h30);
        read_check(1, 7'h30, "R10 memory unchanged after discard");

        report();
        $finish;
    end

endmodule